// File: doc/BRIEF.md
# Streaming ASCII Decimal to Binary Parser

This block turns a decimal number arriving as a stream of ASCII bytes into a 16-bit two's-complement integer. It takes one byte per cycle when `in_valid` is high and reads left to right. A minus sign may appear as the first byte only. Each digit updates a running magnitude, which is multiplied by ten before the digit's value is added. When the string ends, the magnitude is negated if a minus sign was seen.

A string ends in one of two ways. The producer can raise `in_last` on the final byte, and that byte can be a digit. The producer can also send a carriage return or a line feed byte.

One cycle after the byte that ends the string, the block raises `out_valid` for a single cycle. `out_value` then holds the number, or `out_error` is set instead. After an illegal byte or an overflow, the block reports the error at once. It then throws away the rest of that string, so the next string starts clean.

Top module: `dec_ascii_parser`

## Requirements
- R1: While reset is held and right after it is released, `out_valid`, `out_error` and `out_value` are all zero.
- R2: Digits are the bytes 0x30 to 0x39, and each has the value code minus 0x30. They are folded in from the left, starting at zero, as magnitude*10 + digit, so leading zeros have no effect. For example, "123" gives 0x007B.
- R3: A minus byte (0x2D) in the first position marks the number as negative, and the result is the two's complement of the magnitude. For example, "-123" gives 0xFF85.
- R4: A string ends either at a byte sent with `in_last` high or at a CR (0x0D) or LF (0x0A) byte. A digit sent with `in_last` is included in the number; a CR or LF byte is not. The result appears with `out_valid` high in the cycle after the ending byte is accepted.
- R5: Any byte that is not a digit is illegal, except a minus in the first position and a CR or LF after at least one digit. An illegal byte produces `out_valid` with `out_error`=1 and `out_value`=0 in the next cycle. Every later byte of that string, up to and including its ending byte, is dropped and produces no output.
- R6: A positive magnitude above 32767, or a negative magnitude above 32768, is reported as an error when the digit that causes it is accepted. The limit values themselves convert exactly: 32767 gives 0x7FFF and -32768 gives 0x8000.
- R7: A string that ends before any digit (a lone CR or LF, or a lone minus) is reported as an error.
- R8: `out_valid` is high for exactly one cycle per string. `out_value` and `out_error` keep their values until the next result.
- R9: Cycles with `in_valid` low are ignored whatever `in_char` carries. A string may therefore arrive with gaps between its bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is offered in this cycle |
| in_char | input | 8 | ASCII byte |
| in_last | input | 1 | This byte is the final byte of the string |
| out_valid | output | 1 | One-cycle strobe: a result or an error is ready |
| out_value | output | 16 | Parsed two's-complement value (zero on error) |
| out_error | output | 1 | The string that just finished was rejected |

## Verification
Every result, whether a number or an error, is due exactly one cycle after the byte that produces it is accepted. That byte is the terminating byte for a good string, and the illegal or overflowing byte for a bad one. The driver changes inputs on the falling edge, and the scoreboard monitor samples `out_valid` on the falling edge as well. Each report is therefore matched against the oldest expected entry in the same half-cycle window it belongs to. Any strobe that arrives with an empty queue counts as a failure, and so does any expected entry still left over at the end. Together these catch results that are late, duplicated or missing, and bytes that should have been dropped but were not.

// File: rtl/dap_pkg.sv
// Package: shared types for the decimal parser.
// Assumes 8-bit ASCII input bytes.
package dap_pkg;

    // Class of one input byte
    typedef enum logic [1:0] {
        CC_DIGIT = 2'd0,
        CC_MINUS = 2'd1,
        CC_EOL   = 2'd2,
        CC_OTHER = 2'd3
    } char_class_e;

    // Parse position within a string
    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,  // no byte of the string seen yet
        ST_SIGN   = 2'd1,  // minus seen, waiting for the first digit
        ST_DIGITS = 2'd2,  // at least one digit folded in
        ST_DRAIN  = 2'd3   // error reported, dropping bytes to the string end
    } parse_state_e;

endpackage

// File: rtl/dap_char_class.sv
// Module: dap_char_class
// Sorts one ASCII byte into digit, minus, end-of-line or other, and
// gives the numeric value of a digit. Purely combinational.
// Assumes CHAR_W >= 7 so the ASCII codes fit.
module dap_char_class
    import dap_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] chr,
    output char_class_e       cls,
    output logic [3:0]        digit
);
    localparam logic [CHAR_W-1:0] CODE_ZERO  = CHAR_W'(8'h30);
    localparam logic [CHAR_W-1:0] CODE_NINE  = CHAR_W'(8'h39);
    localparam logic [CHAR_W-1:0] CODE_MINUS = CHAR_W'(8'h2D);
    localparam logic [CHAR_W-1:0] CODE_CR    = CHAR_W'(8'h0D);
    localparam logic [CHAR_W-1:0] CODE_LF    = CHAR_W'(8'h0A);

    logic [CHAR_W-1:0] offset;

    // Digit value: subtract the code of '0'
    always_comb begin
        offset = chr - CODE_ZERO;
        digit  = offset[3:0];
    end

    // Byte classification
    always_comb begin
        if (chr >= CODE_ZERO && chr <= CODE_NINE) begin
            cls = CC_DIGIT;
        end else if (chr == CODE_MINUS) begin
            cls = CC_MINUS;
        end else if (chr == CODE_CR || chr == CODE_LF) begin
            cls = CC_EOL;
        end else begin
            cls = CC_OTHER;
        end
    end

endmodule

// File: rtl/dap_mac10.sv
// Module: dap_mac10
// Computes base*10 + digit using shifts and one adder chain, so one digit
// can be folded in per clock. Flags a sum above the limit for the sign:
// 2^(DATA_W-1)-1 for positive, 2^(DATA_W-1) for negative numbers.
// Assumes base never exceeds the negative limit on entry.
module dap_mac10 #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = DATA_W + 1
) (
    input  logic [ACC_W-1:0] base,
    input  logic [3:0]       digit,
    input  logic             neg,
    output logic [ACC_W-1:0] sum,
    output logic             ovf
);
    localparam int MAC_W = ACC_W + 4;
    localparam logic [MAC_W-1:0] POS_LIM =
        {{(MAC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic [MAC_W-1:0] NEG_LIM = POS_LIM + MAC_W'(1);

    logic [MAC_W-1:0] wide_base;
    logic [MAC_W-1:0] wide_sum;

    // Times ten as (x<<3)+(x<<1), plus the digit
    always_comb begin
        wide_base = MAC_W'(base);
        wide_sum  = (wide_base << 3) + (wide_base << 1) + MAC_W'(digit);
        sum       = wide_sum[ACC_W-1:0];
    end

    // Range check against the limit for the current sign
    always_comb begin
        ovf = neg ? (wide_sum > NEG_LIM) : (wide_sum > POS_LIM);
    end

endmodule

// File: rtl/dap_result_fmt.sv
// Module: dap_result_fmt
// Turns an unsigned magnitude and a sign into a two's-complement word.
// Assumes the magnitude is already within range for the sign.
module dap_result_fmt #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = DATA_W + 1
) (
    input  logic [ACC_W-1:0]  mag,
    input  logic              neg,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] low;

    // Conditional negation of the low word
    always_comb begin
        low   = mag[DATA_W-1:0];
        value = neg ? (~low + DATA_W'(1)) : low;
    end

endmodule

// File: rtl/dec_ascii_parser.sv
// Module: dec_ascii_parser (top)
// Streaming ASCII decimal parser. Reads one byte per valid cycle from
// the left, takes an optional leading minus, and accumulates digits.
// A string ends at a byte with in_last or at a CR/LF byte. A result
// or an error strobe follows one cycle after the deciding byte. After
// an error the rest of the string is dropped.
// Assumes the producer sends strings back to back with no framing
// other than in_last or CR/LF.
module dec_ascii_parser
    import dap_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_error
);
    localparam int ACC_W = DATA_W + 1;

    parse_state_e      state_q, state_d;
    logic [ACC_W-1:0]  acc_q, acc_d;
    logic              neg_q, neg_d;

    char_class_e       cls;
    logic [3:0]        digit;
    logic [ACC_W-1:0]  mac_base;
    logic [ACC_W-1:0]  mac_sum;
    logic              mac_ovf;
    logic [ACC_W-1:0]  res_mag;
    logic [DATA_W-1:0] res_value;
    logic              terminal;
    logic              finish;
    logic              fault;

    dap_char_class #(.CHAR_W(CHAR_W)) u_class (
        .chr   (in_char),
        .cls   (cls),
        .digit (digit)
    );

    dap_mac10 #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .base  (mac_base),
        .digit (digit),
        .neg   (neg_d),
        .sum   (mac_sum),
        .ovf   (mac_ovf)
    );

    dap_result_fmt #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_fmt (
        .mag   (res_mag),
        .neg   (neg_d),
        .value (res_value)
    );

    // Operand selection: the first digit starts from zero
    always_comb begin
        mac_base = (state_q == ST_DIGITS) ? acc_q : '0;
        res_mag  = (cls == CC_DIGIT) ? mac_sum : acc_q;
        terminal = in_last || (cls == CC_EOL);
    end

    // Parse step: next state, magnitude, sign, and result/error decision
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        neg_d   = neg_q;
        finish  = 1'b0;
        fault   = 1'b0;
        if (in_valid) begin
            unique case (state_q)
                ST_FIRST: begin
                    unique case (cls)
                        CC_DIGIT: begin
                            neg_d = 1'b0;
                            acc_d = mac_sum;
                            if (in_last) finish = 1'b1;
                            else         state_d = ST_DIGITS;
                        end
                        CC_MINUS: begin
                            neg_d = 1'b1;
                            if (in_last) fault = 1'b1;
                            else         state_d = ST_SIGN;
                        end
                        default: begin
                            fault   = 1'b1;
                            state_d = terminal ? ST_FIRST : ST_DRAIN;
                        end
                    endcase
                end
                ST_SIGN: begin
                    if (cls == CC_DIGIT) begin
                        acc_d = mac_sum;
                        if (in_last) begin
                            finish  = 1'b1;
                            state_d = ST_FIRST;
                        end else begin
                            state_d = ST_DIGITS;
                        end
                    end else begin
                        fault   = 1'b1;
                        state_d = terminal ? ST_FIRST : ST_DRAIN;
                    end
                end
                ST_DIGITS: begin
                    unique case (cls)
                        CC_DIGIT: begin
                            if (mac_ovf) begin
                                fault   = 1'b1;
                                state_d = terminal ? ST_FIRST : ST_DRAIN;
                            end else begin
                                acc_d = mac_sum;
                                if (in_last) begin
                                    finish  = 1'b1;
                                    state_d = ST_FIRST;
                                end
                            end
                        end
                        CC_EOL: begin
                            finish  = 1'b1;
                            state_d = ST_FIRST;
                        end
                        default: begin
                            fault   = 1'b1;
                            state_d = terminal ? ST_FIRST : ST_DRAIN;
                        end
                    endcase
                end
                ST_DRAIN: begin
                    if (terminal) state_d = ST_FIRST;
                end
                default: state_d = ST_FIRST;
            endcase
        end
    end

    // Parse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FIRST;
            acc_q   <= '0;
            neg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            neg_q   <= neg_d;
        end
    end

    // Result registers: one-cycle strobe, value and error held between results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_error <= 1'b0;
        end else begin
            out_valid <= finish || fault;
            if (fault) begin
                out_value <= '0;
                out_error <= 1'b1;
            end else if (finish) begin
                out_value <= res_value;
                out_error <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dap_checker.sv
// Module: dap_checker
// Port-level properties of the decimal parser, bound to every instance.
module dap_checker #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CHAR_W-1:0] in_char,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_value,
    input logic              out_error
);
    logic in_is_digit;
    logic in_is_eol;
    logic in_is_minus;

    // Byte kinds seen at the input, decoded independently of the design
    always_comb begin
        in_is_digit = (in_char >= CHAR_W'(8'h30)) && (in_char <= CHAR_W'(8'h39));
        in_is_eol   = (in_char == CHAR_W'(8'h0D)) || (in_char == CHAR_W'(8'h0A));
        in_is_minus = (in_char == CHAR_W'(8'h2D));
    end

    // R4 R9: a strobe only ever follows an accepted byte
    a_r9_strobe_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R4: a good result is always caused by a digit or by CR/LF
    a_r4_good_by_digit_or_eol: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_error) |-> ($past(in_is_digit) || $past(in_is_eol)));

    // R5: an illegal byte never yields a good result
    a_r5_illegal_not_good: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_is_digit && !in_is_eol && !in_is_minus) |=> (!out_valid || out_error));

    // R5: error reports carry a zero value
    a_r5_error_value_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_error) |-> (out_value == '0));

    // R8: outputs change only together with the strobe
    a_r8_value_held: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_value) && $stable(out_error)));

endmodule

bind dec_ascii_parser dap_checker #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dap_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_char   (in_char),
    .out_valid (out_valid),
    .out_value (out_value),
    .out_error (out_error)
);

// File: tb/tb_dec_ascii_parser.sv
// Scoreboard bench: the driver queues the expected result, then sends the bytes;
// the monitor pops and compares on every strobe.
module tb_dec_ascii_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic [15:0] out_value;
    logic        out_error;

    typedef struct {
        logic [15:0] value;
        bit          err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dec_ascii_parser dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_char   (in_char),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_value (out_value),
        .out_error (out_error)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_res(input logic [15:0] v, input bit e, input string tag);
        exp_t x;
        x.value = v;
        x.err = e;
        x.tag = tag;
        exp_q.push_back(x);
    endtask

    // Send a string one byte per cycle; gap idle cycles carry junk bytes (R9)
    task automatic send(input string s, input bit mark_last, input int gap);
        for (int i = 0; i < s.len(); i++) begin
            in_valid = 1'b1;
            in_char  = s[i];
            in_last  = mark_last && (i == s.len() - 1);
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b0;
            in_char  = 8'h78;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    // Monitor: compare each strobe with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 R9 unexpected strobe", out_value, 16'h0000);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(out_error == x.err, {x.tag, " error flag"},
                      {15'd0, out_error}, {15'd0, x.err});
                check(out_value == x.value, {x.tag, " value"}, out_value, x.value);
            end
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_error == 1'b0, "R1 reset flags",
              {14'd0, out_valid, out_error}, 16'h0000);
        check(out_value == 16'h0000, "R1 reset value", out_value, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_value == 16'h0000, "R1 after release",
              out_value, 16'h0000);

        expect_res(16'h007B, 1'b0, "R2 123");
        send("123", 1'b1, 0);
        @(negedge clk);
        held = out_value;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0 && out_value == held, "R8 hold", out_value, held);
        end

        expect_res(16'hFF85, 1'b0, "R3 -123");
        send("-123", 1'b1, 0);
        expect_res(16'd45, 1'b0, "R4 CR end");
        send("45\015", 1'b0, 0);
        expect_res(16'hFFF9, 1'b0, "R3 R4 LF end");
        send("-7\012", 1'b0, 0);
        expect_res(16'h7FFF, 1'b0, "R6 max positive");
        send("32767", 1'b1, 0);
        expect_res(16'h0000, 1'b1, "R6 positive overflow");
        send("32768", 1'b1, 0);
        expect_res(16'h8000, 1'b0, "R6 min negative");
        send("-32768", 1'b1, 0);
        expect_res(16'h0000, 1'b1, "R6 negative overflow");
        send("-32769", 1'b1, 0);
        expect_res(16'h0000, 1'b1, "R6 overflow then drain");
        send("40000\012", 1'b0, 0);
        expect_res(16'h0000, 1'b1, "R5 illegal mid string");
        send("12a45", 1'b1, 0);
        expect_res(16'd9, 1'b0, "R5 recovery");
        send("9", 1'b1, 0);
        expect_res(16'h0000, 1'b1, "R5 drain to LF");
        send("5x6\012", 1'b0, 0);
        expect_res(16'h0000, 1'b1, "R5 minus after digit");
        send("1-2", 1'b1, 0);
        expect_res(16'h0000, 1'b1, "R5 double minus");
        send("--5", 1'b1, 0);
        expect_res(16'h0000, 1'b1, "R7 lone LF");
        send("\012", 1'b0, 0);
        expect_res(16'h0000, 1'b1, "R7 lone minus");
        send("-", 1'b1, 0);
        expect_res(16'd42, 1'b0, "R2 R9 leading zeros with gaps");
        send("0042", 1'b1, 2);
        expect_res(16'd1, 1'b0, "R8 back to back 1");
        expect_res(16'd2, 1'b0, "R8 back to back 2");
        send("1", 1'b1, 0);
        send("2", 1'b1, 0);
        expect_res(16'hFFFF, 1'b0, "R3 R9 -1 with gaps");
        send("-1\015", 1'b0, 3);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 missing results", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule